// File: doc/BRIEF.md
# UART receive frame matcher

This block follows the deserializer of a UART receiver. It checks each completed frame against two programmable patterns, one that marks the start of a message and one that marks a signal. A match raises a sticky event flag. The block also keeps a blocked state, which decides whether received frames are passed on to the receive buffer.

Software can set the blocked state, so that the receiver ignores traffic until a start frame arrives. The start frame itself is always passed to the buffer. If unblocking on start frames is enabled, that same frame also releases the block, so the rest of the message flows through without software having to act. Frames with a framing error are dropped before any comparison is made. When frames are shorter than nine bits, the comparison ignores the pattern bits above the configured frame length.

Top module: `uart_frame_matcher`

## Requirements
- R1: A frame is compared only on its lowest `frame_len_i` bits. A `frame_len_i` of 0, or a value above 9, compares all 9 bits.
- R2: A good frame that equals the start pattern sets `start_flag_o` on the next clock edge.
- R3: A good frame that equals the signal pattern sets `sig_flag_o` on the next clock edge. This happens even while blocked, and a single frame can set both flags.
- R4: Each flag stays set until a one-cycle pulse on its clear bit: `evt_clr_i[0]` clears the start flag and `evt_clr_i[1]` clears the signal flag. If a set and a clear fall in the same cycle, the flag stays set.
- R5: While not blocked, every good frame causes `buf_wr_o` to be high for one cycle, one cycle after `frame_valid_i`. In that cycle `buf_data_o` carries all 9 received bits.
- R6: While blocked, a good frame that does not match the start pattern produces no buffer write.
- R7: A good frame that matches the start pattern is always written to the buffer, even while blocked. If `start_unblock_en_i` is high, the same frame also clears the blocked state, in the same cycle as the write.
- R8: `block_set_i` sets `blocked_o` and `block_clr_i` clears it. When both arrive together, the set wins. A start-match unblock wins over both.
- R9: A frame presented with `frame_err_i` high writes nothing and sets no flag.
- R10: `irq_o` equals `(start_flag_o & irq_en_i[0]) | (sig_flag_o & irq_en_i[1])`. It is combinational.
- R11: After reset, `blocked_o`, both flags and `buf_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | A received frame is complete |
| frame_data_i | input | 9 | Received frame bits |
| frame_err_i | input | 1 | The frame has a framing error |
| frame_len_i | input | 4 | Data bits per frame (1..9; 0 means 9) |
| start_pat_i | input | 9 | Start pattern |
| sig_pat_i | input | 9 | Signal pattern |
| start_unblock_en_i | input | 1 | A start match releases the block |
| block_set_i | input | 1 | Set the blocked state |
| block_clr_i | input | 1 | Clear the blocked state |
| evt_clr_i | input | 2 | Clear pulse per flag: [0] start, [1] signal |
| irq_en_i | input | 2 | Interrupt enable per flag: [0] start, [1] signal |
| buf_wr_o | output | 1 | Write strobe to the receive buffer |
| buf_data_o | output | 9 | Data to write to the buffer |
| blocked_o | output | 1 | Receive is blocked |
| start_flag_o | output | 1 | Sticky start-frame event |
| sig_flag_o | output | 1 | Sticky signal-frame event |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a start-pattern match that unblocks, arriving together with a block-set command. The bench drives both on one clock edge and expects `blocked_o` to read low afterwards, with the frame written. The second pair is a flag set and its clear pulse on the same edge. The bench drives a matching frame together with `evt_clr_i` and expects the flag to stay high. A later clear on its own must then drop the flag.

// File: rtl/ufm_pkg.sv
package ufm_pkg;
  localparam int EV_START = 0;
  localparam int EV_SIG   = 1;
  localparam int NUM_EV   = 2;
endpackage

// File: rtl/ufm_pattern_cmp.sv
module ufm_pattern_cmp #(
  parameter int DATA_W = 9,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] pat_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] mask;
  int unsigned       eff_len;

  // length 0 or out of range compares the full width
  always_comb begin
    eff_len = (len_i == '0 || int'(len_i) > DATA_W) ? DATA_W : int'(len_i);
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < eff_len);
    hit_o = (((data_i ^ pat_i) & mask) == '0);
  end
endmodule

// File: rtl/ufm_event_flag.sv
module ufm_event_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/ufm_block_ctrl.sv
module ufm_block_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unblock_i,
  input  logic set_i,
  input  logic clr_i,
  output logic blocked_o
);
  // unblock beats set, set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        blocked_o <= 1'b0;
    else if (unblock_i) blocked_o <= 1'b0;
    else if (set_i)     blocked_o <= 1'b1;
    else if (clr_i)     blocked_o <= 1'b0;
  end

  p_unblock_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unblock_i |=> !blocked_o);
  p_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !unblock_i) |=> blocked_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unblock_i && !set_i && !clr_i) |=> $stable(blocked_o));
endmodule

// File: rtl/uart_frame_matcher.sv
module uart_frame_matcher
  import ufm_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              frame_err_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic [DATA_W-1:0] start_pat_i,
  input  logic [DATA_W-1:0] sig_pat_i,
  input  logic              start_unblock_en_i,
  input  logic              block_set_i,
  input  logic              block_clr_i,
  input  logic [NUM_EV-1:0] evt_clr_i,
  input  logic [NUM_EV-1:0] irq_en_i,
  output logic              buf_wr_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              blocked_o,
  output logic              start_flag_o,
  output logic              sig_flag_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] pats [NUM_EV];
  logic [NUM_EV-1:0] hit;
  logic [NUM_EV-1:0] flags;
  logic              accept;
  logic              start_hit;
  logic              do_write;

  assign pats[EV_START] = start_pat_i;
  assign pats[EV_SIG]   = sig_pat_i;
  assign accept         = frame_valid_i && !frame_err_i;
  assign start_hit      = accept && hit[EV_START];

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    logic match;
    ufm_pattern_cmp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cmp (
      .data_i (frame_data_i),
      .pat_i  (pats[g]),
      .len_i  (frame_len_i),
      .hit_o  (hit[g])
    );
    assign match = accept && hit[g];
    ufm_event_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (match),
      .clr_i  (evt_clr_i[g]),
      .q_o    (flags[g])
    );
  end

  ufm_block_ctrl u_block (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unblock_i (start_hit && start_unblock_en_i),
    .set_i     (block_set_i),
    .clr_i     (block_clr_i),
    .blocked_o (blocked_o)
  );

  // start match passes even while blocked
  assign do_write = accept && (!blocked_o || hit[EV_START]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_wr_o   <= 1'b0;
      buf_data_o <= '0;
    end else begin
      buf_wr_o <= do_write;
      if (do_write) buf_data_o <= frame_data_i;
    end
  end

  assign start_flag_o = flags[EV_START];
  assign sig_flag_o   = flags[EV_SIG];
  assign irq_o        = |(flags & irq_en_i);

  p_blocked_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_o && accept && !hit[EV_START]) |=> !buf_wr_o);
  p_start_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_hit |=> buf_wr_o);
  p_err_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && frame_err_i) |=> !buf_wr_o);
  p_open_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blocked_o && accept) |=> buf_wr_o);
  p_wr_needs_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> $past(frame_valid_i));
endmodule

// File: tb/uart_frame_matcher_bench.sv
module uart_frame_matcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] START_PAT = 9'h1A5;
  localparam logic [8:0] SIG_PAT   = 9'h0F3;

  typedef struct packed {
    logic       valid;
    logic [8:0] data;
    logic       err;
    logic [3:0] len;
    logic       ub;
    logic       bset;
    logic       bclr;
    logic       ewr;
    logic       eblk;
    logic       esf;
    logic       egf;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 9'h055, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 plain
    '{1'b1, 9'h1A5, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R2
    '{1'b1, 9'h0F3, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R3
    '{1'b0, 9'h000, 1'b0, 4'd9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 set
    '{1'b1, 9'h055, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 drop
    '{1'b1, 9'h0F3, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 while blocked
    '{1'b1, 9'h1A5, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 no unblock
    '{1'b1, 9'h1A5, 1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 unblock
    '{1'b1, 9'h055, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 after unblock
    '{1'b1, 9'h1A5, 1'b0, 4'd9, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R8 unblock beats set
    '{1'b0, 9'h000, 1'b0, 4'd9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 set beats clr
    '{1'b0, 9'h000, 1'b0, 4'd9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 clr
    '{1'b1, 9'h0A5, 1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 len 8
    '{1'b1, 9'h1F3, 1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R1 len 8 sig
    '{1'b1, 9'h005, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 len 4
    '{1'b1, 9'h1A5, 1'b1, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 framing err
    '{1'b1, 9'h1A5, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 len 0
    '{1'b1, 9'h001, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}  // R3 both flags
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_valid = 1'b0;
  logic [8:0] frame_data = '0;
  logic       frame_err = 1'b0;
  logic [3:0] frame_len = 4'd9;
  logic       unblock_en = 1'b0;
  logic       bset = 1'b0;
  logic       bclr = 1'b0;
  logic [1:0] evt_clr = '0;
  logic [1:0] irq_en = 2'b11;
  logic       buf_wr;
  logic [8:0] buf_data;
  logic       blocked, start_flag, sig_flag, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_matcher u_uart_frame_matcher (
    .clk_i              (clk),
    .rst_ni             (rst_n),
    .frame_valid_i      (frame_valid),
    .frame_data_i       (frame_data),
    .frame_err_i        (frame_err),
    .frame_len_i        (frame_len),
    .start_pat_i        (START_PAT),
    .sig_pat_i          (SIG_PAT),
    .start_unblock_en_i (unblock_en),
    .block_set_i        (bset),
    .block_clr_i        (bclr),
    .evt_clr_i          (evt_clr),
    .irq_en_i           (irq_en),
    .buf_wr_o           (buf_wr),
    .buf_data_o         (buf_data),
    .blocked_o          (blocked),
    .start_flag_o       (start_flag),
    .sig_flag_o         (sig_flag),
    .irq_o              (irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    frame_valid = 1'b0; frame_err = 1'b0; unblock_en = 1'b0;
    bset = 1'b0; bclr = 1'b0; evt_clr = '0;
  endtask

  task automatic clear_flags();
    @(negedge clk); idle(); evt_clr = 2'b11;
    @(negedge clk); evt_clr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "blocked", int'(blocked), 0);
    chk("R11", "start_flag", int'(start_flag), 0);
    chk("R11", "buf_wr", int'(buf_wr), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      frame_valid = VECS[i].valid; frame_data = VECS[i].data;
      frame_err = VECS[i].err; frame_len = VECS[i].len;
      unblock_en = VECS[i].ub; bset = VECS[i].bset; bclr = VECS[i].bclr;
      @(negedge clk);
      chk("R5/R6/R7/R9", $sformatf("v%0d buf_wr", i), int'(buf_wr), int'(VECS[i].ewr));
      if (VECS[i].ewr)
        chk("R5", $sformatf("v%0d buf_data", i), int'(buf_data), int'(VECS[i].data));
      chk("R7/R8", $sformatf("v%0d blocked", i), int'(blocked), int'(VECS[i].eblk));
      chk("R1/R2", $sformatf("v%0d start_flag", i), int'(start_flag), int'(VECS[i].esf));
      chk("R1/R3", $sformatf("v%0d sig_flag", i), int'(sig_flag), int'(VECS[i].egf));
      idle();
      clear_flags();
    end
    frame_len = 4'd9;

    // R4 sticky
    @(negedge clk); frame_valid = 1'b1; frame_data = START_PAT;
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    chk("R4", "sticky start_flag", int'(start_flag), 1);
    // R10 interrupt masking
    irq_en = 2'b10; #1;
    chk("R10", "irq masked", int'(irq), 0);
    irq_en = 2'b01; #1;
    chk("R10", "irq enabled", int'(irq), 1);
    // R4 set and clear together
    @(negedge clk); frame_valid = 1'b1; frame_data = START_PAT; evt_clr = 2'b01;
    @(negedge clk); idle();
    chk("R4", "set beats clear", int'(start_flag), 1);
    @(negedge clk); evt_clr = 2'b01;
    @(negedge clk); idle();
    chk("R4", "cleared", int'(start_flag), 0);
    chk("R10", "irq after clear", int'(irq), 0);

    // R11 reset mid-run
    @(negedge clk); bset = 1'b1;
    @(negedge clk); idle();
    chk("R8", "blocked set", int'(blocked), 1);
    rst_n = 1'b0; #1;
    chk("R11", "reset clears blocked", int'(blocked), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule